// File: doc/BRIEF.md
# Three-State Unbalanced Pulse Encoder

This block turns a stream of signed multi-bit words from an upstream noise-shaping modulator into two single-bit drive streams, `pwm_p` and `pwm_n`, for a switching output stage. Each word occupies one word period of `2**(WORD_W-1)` fast clock slots. A positive word produces one pulse on `pwm_p`, a negative word produces one pulse on `pwm_n`, and the pulse is as many slots long as the magnitude of the word. The output that the sign does not select stays low, so the pair has three states (P high, N high, both low) and is not a complementary differential signal.

Words arrive on a one-cycle strobe at any slot of a period. They are parked in a pending register and become active only at the next period boundary, so a pulse in progress always runs to its end. The two outputs must never change in the same slot. The only transition where they could is a full-length N pulse followed by a positive word. In that case a guard delays the P pulse by one slot and ends it before the last slot of the period. The parameter `MISS_MODE` selects what plays in a period that received no word: silence, or a repeat of the previous word.

Top module: `tspwm_encoder`

## Requirements
- R1: While `rst` is high and in the first word period after it falls, both outputs are low. The slot counter starts at slot 0 on the first clock after reset.
- R2: A word period is `S = 2**(WORD_W-1)` clock slots. A word strobed during period j is active for all of period j+1, and strobes during a period never alter that period's output.
- R3: An active positive word m (bit `WORD_W-1` = 0, m > 0) drives `pwm_p` high in slots 0 to m-1 and keeps `pwm_n` low, unless R7 applies.
- R4: An active negative word -m drives `pwm_n` high in slots 0 to m-1 and keeps `pwm_p` low. The most negative word (only bit `WORD_W-1` set) keeps `pwm_n` high in all S slots.
- R5: An active word of zero holds both outputs low for the whole period.
- R6: `pwm_p` and `pwm_n` are never high together, and never both change value across the same clock edge.
- R7: If `pwm_n` was high in the last slot of the previous period and the active word m is positive, `pwm_p` is high from slot 1 to slot min(m, S-2), and low otherwise.
- R8: If several strobes fall in one period, the last one sets the next word. This includes a strobe in the final slot of the period.
- R9: In a period with no strobe, the next period plays zero when `MISS_MODE` is `MISS_SILENT`. When `MISS_MODE` is `MISS_REPEAT`, it plays the previously active word again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast slot clock |
| rst | input | 1 | Synchronous reset, active high |
| word_valid | input | 1 | One-cycle strobe marking `word_in` as a new word |
| word_in | input | WORD_W | Two's complement input word |
| pwm_p | output | 1 | Positive pulse stream |
| pwm_n | output | 1 | Negative pulse stream |

## Verification
The bench builds two instances with `WORD_W = 4`, which gives eight slots per period: one with `MISS_SILENT` and one with `MISS_REPEAT`. This small width makes it possible to play every ordered pair of the sixteen words back to back. Every transition, including most-negative followed by every positive value, therefore meets the guard, and every slot of every period is compared with an arithmetic model. Directed periods then add strobes in the final slot, several strobes in one period, and periods with no strobe, which separates the two missing-word modes.

// File: rtl/tspwm_pkg.sv
package tspwm_pkg;

   // Behaviour for a word period in which no new word was strobed
   typedef enum logic {
      MISS_SILENT = 1'b0,
      MISS_REPEAT = 1'b1
   } miss_mode_e;

   localparam int unsigned MIN_WORD_W = 2;
   localparam int unsigned MAX_WORD_W = 12;

endpackage

// File: rtl/tspwm_slot_timer.sv
module tspwm_slot_timer #(
   parameter int unsigned CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst,
   output logic [CNT_W-1:0] slot,
   output logic             last_slot
);

   localparam logic [CNT_W-1:0] SLOT_MAX = {CNT_W{1'b1}};

   logic [CNT_W-1:0] slot_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         slot_q <= '0;
      end else if (slot_q == SLOT_MAX) begin
         slot_q <= '0;
      end else begin
         slot_q <= slot_q + 1'b1;
      end
   end

   assign slot      = slot_q;
   assign last_slot = (slot_q == SLOT_MAX);

   // R1: counter begins at slot 0 right after reset
   a_r1_start_zero: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (slot_q == '0));

   // R2: the period wraps after the final slot
   a_r2_wrap: assert property (@(posedge clk) disable iff (rst)
      (slot_q == SLOT_MAX) |=> (slot_q == '0));

   // R2: slots advance one per clock inside a period
   a_r2_step: assert property (@(posedge clk) disable iff (rst)
      (slot_q != SLOT_MAX) |=> (slot_q == $past(slot_q) + 1'b1));

endmodule

// File: rtl/tspwm_word_latch.sv
module tspwm_word_latch
   import tspwm_pkg::*;
#(
   parameter int unsigned WORD_W    = 6,
   parameter miss_mode_e  MISS_MODE = MISS_SILENT
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              boundary,
   input  logic              word_valid,
   input  logic [WORD_W-1:0] word_in,
   output logic [WORD_W-1:0] act_word
);

   logic [WORD_W-1:0] pend_q;
   logic              pend_v_q;
   logic [WORD_W-1:0] act_q;
   logic [WORD_W-1:0] miss_word;

   generate
      if (MISS_MODE == MISS_REPEAT) begin : g_repeat
         assign miss_word = act_q;
      end else begin : g_silent
         assign miss_word = '0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         pend_q   <= '0;
         pend_v_q <= 1'b0;
         act_q    <= '0;
      end else if (boundary) begin
         // a strobe on the final slot is the newest word and wins
         if (word_valid) begin
            act_q <= word_in;
         end else if (pend_v_q) begin
            act_q <= pend_q;
         end else begin
            act_q <= miss_word;
         end
         pend_v_q <= 1'b0;
      end else if (word_valid) begin
         pend_q   <= word_in;
         pend_v_q <= 1'b1;
      end
   end

   assign act_word = act_q;

   // R2: the active word never changes inside a period
   a_r2_hold_active: assert property (@(posedge clk) disable iff (rst)
      !boundary |=> $stable(act_q));

   // R8: a strobe on the final slot is the next active word
   a_r8_final_slot: assert property (@(posedge clk) disable iff (rst)
      (boundary && word_valid) |=> (act_q == $past(word_in)));

endmodule

// File: rtl/tspwm_pulse_gen.sv
module tspwm_pulse_gen #(
   parameter int unsigned WORD_W = 6
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [WORD_W-2:0] slot,
   input  logic              boundary,
   input  logic [WORD_W-1:0] act_word,
   output logic              p_out,
   output logic              n_out
);

   localparam int unsigned       SLOTS    = 1 << (WORD_W - 1);
   localparam logic [WORD_W:0]   LAST_END = (WORD_W+1)'(SLOTS - 1);
   localparam logic [WORD_W-1:0] MOST_NEG = {1'b1, {(WORD_W-1){1'b0}}};

   logic              sgn;
   logic              is_pos;
   logic [WORD_W-1:0] mag;
   logic [WORD_W:0]   slot_x;
   logic [WORD_W:0]   p_start;
   logic [WORD_W:0]   p_stop_raw;
   logic [WORD_W:0]   p_stop;
   logic              tail_n_q;

   always_comb begin
      sgn        = act_word[WORD_W-1];
      is_pos     = !sgn && (act_word != '0);
      mag        = sgn ? (~act_word + 1'b1) : act_word;
      slot_x     = {2'b00, slot};
      // guard: N was high at the end of last period, so P waits one slot
      p_start    = (is_pos && tail_n_q) ? (WORD_W+1)'(1) : '0;
      p_stop_raw = {1'b0, mag} + p_start;
      p_stop     = (p_stop_raw > LAST_END) ? LAST_END : p_stop_raw;
      p_out      = is_pos && (slot_x >= p_start) && (slot_x < p_stop);
      n_out      = sgn && (slot_x < {1'b0, mag});
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         tail_n_q <= 1'b0;
      end else if (boundary) begin
         tail_n_q <= n_out;
      end
   end

   // R6: the two streams are exclusive
   a_r6_exclusive: assert property (@(posedge clk) disable iff (rst)
      !(p_out && n_out));

   // R5: a zero word keeps the stage idle
   a_r5_zero_idle: assert property (@(posedge clk) disable iff (rst)
      (act_word == '0) |-> (!p_out && !n_out));

   // R4: the most negative word fills every slot on N
   a_r4_full_n: assert property (@(posedge clk) disable iff (rst)
      (act_word == MOST_NEG) |-> n_out);

   // R3: unguarded positive pulses start on slot 0
   a_r3_start_slot0: assert property (@(posedge clk) disable iff (rst)
      (slot == '0 && is_pos && !tail_n_q) |-> p_out);

   // R7: P is never high in the final slot of a period
   a_r7_no_p_last: assert property (@(posedge clk) disable iff (rst)
      boundary |-> !p_out);

endmodule

// File: rtl/tspwm_encoder.sv
module tspwm_encoder
   import tspwm_pkg::*;
#(
   parameter int unsigned WORD_W    = 6,
   parameter miss_mode_e  MISS_MODE = MISS_SILENT
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              word_valid,
   input  logic [WORD_W-1:0] word_in,
   output logic              pwm_p,
   output logic              pwm_n
);

   localparam int unsigned CNT_W = WORD_W - 1;

   generate
      if (WORD_W < MIN_WORD_W || WORD_W > MAX_WORD_W) begin : g_bad_width
         $error("tspwm_encoder: WORD_W outside supported range");
      end
   endgenerate

   logic [CNT_W-1:0]  slot;
   logic              last_slot;
   logic [WORD_W-1:0] act_word;
   logic              p_int;
   logic              n_int;

   tspwm_slot_timer #(
      .CNT_W (CNT_W)
   ) timer_i (
      .clk       (clk),
      .rst       (rst),
      .slot      (slot),
      .last_slot (last_slot)
   );

   tspwm_word_latch #(
      .WORD_W    (WORD_W),
      .MISS_MODE (MISS_MODE)
   ) latch_i (
      .clk        (clk),
      .rst        (rst),
      .boundary   (last_slot),
      .word_valid (word_valid),
      .word_in    (word_in),
      .act_word   (act_word)
   );

   tspwm_pulse_gen #(
      .WORD_W (WORD_W)
   ) pulse_i (
      .clk      (clk),
      .rst      (rst),
      .slot     (slot),
      .boundary (last_slot),
      .act_word (act_word),
      .p_out    (p_int),
      .n_out    (n_int)
   );

   assign pwm_p = p_int;
   assign pwm_n = n_int;

   // R6: the outputs never switch across the same edge
   a_r6_no_dual_toggle: assert property (@(posedge clk) disable iff (rst)
      !((pwm_p != $past(pwm_p)) && (pwm_n != $past(pwm_n))));

endmodule

// File: tb/tspwm_encoder_tb_top.sv
module tspwm_encoder_tb_top;
   import tspwm_pkg::*;

   localparam int W = 4;
   localparam int S = 1 << (W - 1);
   localparam logic [W-1:0] MNEG = {1'b1, {(W-1){1'b0}}};

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         word_valid = 1'b0;
   logic [W-1:0] word_in = '0;
   logic         p0, n0, p1, n1;

   int tests = 0;
   int fails = 0;
   bit done  = 0;

   // model state per instance: active word and N-tail flag
   logic [W-1:0] cur0 = '0, cur1 = '0;
   logic         tail0 = 1'b0, tail1 = 1'b0;
   logic         pp0 = 1'b0, pn0 = 1'b0, pp1 = 1'b0, pn1 = 1'b0;

   always #10 clk = ~clk;

   tspwm_encoder #(.WORD_W(W), .MISS_MODE(MISS_SILENT)) dut_i (
      .clk(clk), .rst(rst), .word_valid(word_valid), .word_in(word_in),
      .pwm_p(p0), .pwm_n(n0));

   tspwm_encoder #(.WORD_W(W), .MISS_MODE(MISS_REPEAT)) dut_hold_i (
      .clk(clk), .rst(rst), .word_valid(word_valid), .word_in(word_in),
      .pwm_p(p1), .pwm_n(n1));

   task automatic check(input string req, input string what,
                        input logic act, input logic exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
      end
   endtask

   function automatic logic exp_p(input int s, input logic [W-1:0] w, input logic tl);
      int v   = $signed(w);
      int off = (v > 0 && tl) ? 1 : 0;
      int e   = v + off;
      if (e > S - 1) e = S - 1;
      return (v > 0) && (s >= off) && (s < e);
   endfunction

   function automatic logic exp_n(input int s, input logic [W-1:0] w);
      int v = $signed(w);
      return (v < 0) && (s < -v);
   endfunction

   function automatic string tag(input logic [W-1:0] w, input logic tl);
      int v = $signed(w);
      if (v == 0) return "R5";
      if (v < 0)  return "R4";
      return tl ? "R7" : "R3";
   endfunction

   // one period; strobes at slots at0/at1 (-1 = none). R2: strobes do not alter this period.
   task automatic run_period(input logic [W-1:0] w0, input int at0,
                             input logic [W-1:0] w1, input int at1);
      for (int s = 0; s < S; s++) begin
         check(tag(cur0, tail0), $sformatf("silent P slot %0d word %0d", s, $signed(cur0)), p0, exp_p(s, cur0, tail0));
         check(tag(cur0, tail0), $sformatf("silent N slot %0d word %0d", s, $signed(cur0)), n0, exp_n(s, cur0));
         check(tag(cur1, tail1), $sformatf("repeat P slot %0d word %0d", s, $signed(cur1)), p1, exp_p(s, cur1, tail1));
         check(tag(cur1, tail1), $sformatf("repeat N slot %0d word %0d", s, $signed(cur1)), n1, exp_n(s, cur1));
         // R6: exclusive and never a joint toggle
         check("R6", "silent joint toggle", (p0 != pp0) && (n0 != pn0), 1'b0);
         check("R6", "repeat joint toggle", (p1 != pp1) && (n1 != pn1), 1'b0);
         pp0 = p0; pn0 = n0; pp1 = p1; pn1 = n1;
         word_valid = 1'b0;
         if (s == at0) begin word_valid = 1'b1; word_in = w0; end
         if (s == at1) begin word_valid = 1'b1; word_in = w1; end
         @(negedge clk);
      end
      word_valid = 1'b0;
      tail0 = (cur0 == MNEG);
      tail1 = (cur1 == MNEG);
      if (at1 >= 0) begin
         cur0 = w1; cur1 = w1;
      end else if (at0 >= 0) begin
         cur0 = w0; cur1 = w0;
      end else begin
         cur0 = '0; // R9: silent mode plays zero, repeat mode keeps cur1
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      // R1: outputs low during reset
      check("R1", "silent P in reset", p0, 1'b0);
      check("R1", "silent N in reset", n0, 1'b0);
      check("R1", "repeat P in reset", p1, 1'b0);
      check("R1", "repeat N in reset", n1, 1'b0);
      rst = 1'b0;
      // R1: first period after reset is idle
      run_period('0, -1, '0, -1);
      // R2, R3, R4, R5, R7: every ordered pair of words back to back
      for (int a = 0; a < (1 << W); a++) begin
         for (int b = 0; b < (1 << W); b++) begin
            run_period(W'(a), 3, '0, -1);
            run_period(W'(b), 5, '0, -1);
         end
      end
      // R8: two strobes, the later one in the final slot wins
      run_period(W'(3), 1, W'(-5), S - 1);
      run_period(W'(2), 2, W'(1), 6);
      // R9: no strobes: silent falls to zero, repeat replays the word
      run_period('0, -1, '0, -1);
      run_period('0, -1, '0, -1);
      run_period(MNEG, 0, '0, -1);
      run_period('0, -1, '0, -1);
      run_period('0, -1, '0, -1);
      run_period('0, -1, '0, -1);
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule